// File: doc/BRIEF.md
# I2C Pin Recovery Multiplexer

This block sits between an I2C protocol engine and the two open-drain pads of the bus. In normal operation it passes the engine's pull-down enables straight to the pads. When software sets a single mode bit, both pads come under direct register control. Software can then clock SCL by hand while it watches SDA, to free a target that holds the bus low. The block only provides the register access. Generating the recovery pulse train is left to software.

The pads are open-drain. An enable output of 1 pulls the line low, and 0 releases it. In register mode, each pad has an output latch and a direction bit. A latch level of 1 releases the line and 0 pulls it low, and the pad is driven only when its direction bit selects output. Separate write-only set and clear registers change the latches without a read-modify-write. Pad levels reach software through a two-flop synchroniser. While register mode is active, an engine hold output keeps the protocol engine in reset, so that it is reinitialised when the pads are handed back.

Top module: `i2c_pin_recovery_mux`

## Requirements
- R1: After reset, the mode bit is 0, both direction bits are 0 and both output latches are 1 (released), so the pad enables equal the engine enables.
- R2: The mode register is at byte offset 0x48. Bit 0 = 1 puts both pads under register control, and bit 0 = 0 returns them to the engine. It reads back in bit 0, and the mode changes only when that offset is written.
- R3: The direction register is at offset 0x4C. Bit 0 = 1 makes SCL an output and bit 1 = 1 makes SDA an output. It reads back in bits 1:0, and it changes only when that offset is written.
- R4: In register mode, a pad whose direction bit is 0 has its enable at 0, whatever its latch holds.
- R5: Writing offset 0x58 sets the latch of each pad whose bit is 1 (bit 0 = SCL, bit 1 = SDA), which releases the line. Zero bits leave their latch unchanged, and the offset reads as 0.
- R6: Writing offset 0x5C clears the latch of each pad whose bit is 1 (bit 0 = SCL, bit 1 = SDA), so that an output pad pulls its line low. Zero bits leave their latch unchanged, and the offset reads as 0.
- R7: Offset 0x50 reads the SCL level in bit 0 and the SDA level in bit 1. A level change at a pad input shows in the read data after the second rising clock edge. Both synchroniser stages reset to 1.
- R8: The engine hold output is 1 exactly while register mode is selected.
- R9: Any other offset reads as 0, and writes to it change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 8 | Register byte offset |
| reg_wdata_i | input | 16 | Write data |
| reg_rdata_o | output | 16 | Read data for reg_addr_i (combinational) |
| eng_scl_oe_i | input | 1 | Engine SCL pull-down enable |
| eng_sda_oe_i | input | 1 | Engine SDA pull-down enable |
| scl_i | input | 1 | SCL pad level |
| sda_i | input | 1 | SDA pad level |
| scl_oe_o | output | 1 | SCL pad pull-down enable |
| sda_oe_o | output | 1 | SDA pad pull-down enable |
| eng_hold_o | output | 1 | Holds the engine in reset while in register mode |

## Verification
Two things can coincide in one cycle. A write to the mode register can arrive while the engine toggles its pull-down enables, and a pad level can change while the input register is being read. The random stimulus draws engine enables, pad levels and register writes independently every cycle, so both cases occur often. A bench model then predicts each pad enable from the mode bit in effect after the write's clock edge, and the read data from the pad history two edges back. A directed sequence also pulls SCL low while reading the input register and checks the old value on the first cycle after the change and the new value only after the second edge.

// File: rtl/i2c_rcv_pkg.sv
package i2c_rcv_pkg;
  localparam int unsigned NUM_PINS = 2;
  localparam int unsigned PIN_SCL  = 0;
  localparam int unsigned PIN_SDA  = 1;
  localparam logic [7:0] OFF_MODE = 8'h48;
  localparam logic [7:0] OFF_DIR  = 8'h4C;
  localparam logic [7:0] OFF_LVL  = 8'h50;
  localparam logic [7:0] OFF_SET  = 8'h58;
  localparam logic [7:0] OFF_CLR  = 8'h5C;
endpackage

// File: rtl/i2c_rcv_sync.sv
module i2c_rcv_sync #(
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic s1_q, s2_q;
  logic [1:0] age_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= RST_VAL;
      s2_q <= RST_VAL;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  // cycles since reset, saturating, gates the latency check
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) age_q <= '0;
    else if (age_q != 2'd2) age_q <= age_q + 2'd1;
  end

  assign q_o = s2_q;

  AST_SYNC_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age_q == 2'd2) |-> (q_o == $past(d_i, 2))) else $error("sync latency"); // R7
endmodule

// File: rtl/i2c_rcv_regs.sv
module i2c_rcv_regs #(
  parameter int unsigned AW = 8,
  parameter int unsigned DW = 16,
  parameter int unsigned NP = 2,
  parameter logic [AW-1:0] OFF_MODE = 8'h48,
  parameter logic [AW-1:0] OFF_DIR  = 8'h4C,
  parameter logic [AW-1:0] OFF_LVL  = 8'h50,
  parameter logic [AW-1:0] OFF_SET  = 8'h58,
  parameter logic [AW-1:0] OFF_CLR  = 8'h5C
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  input  logic [NP-1:0] pin_sync_i,
  output logic          mode_o,
  output logic [NP-1:0] dir_o,
  output logic [NP-1:0] lvl_o
);
  localparam int unsigned PADW = DW - NP;

  logic          mode_q;
  logic [NP-1:0] dir_q, lvl_q, wbits;
  logic          wr_mode, wr_dir, wr_set, wr_clr;

  assign wbits   = wdata_i[NP-1:0];
  assign wr_mode = we_i && (addr_i == OFF_MODE);
  assign wr_dir  = we_i && (addr_i == OFF_DIR);
  assign wr_set  = we_i && (addr_i == OFF_SET);
  assign wr_clr  = we_i && (addr_i == OFF_CLR);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= 1'b0;
      dir_q  <= '0;
    end else begin
      if (wr_mode) mode_q <= wdata_i[0];
      if (wr_dir)  dir_q  <= wbits;
    end
  end

  // latches reset released; set and clear are separate offsets
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     lvl_q <= '1;
    else if (wr_set) lvl_q <= lvl_q | wbits;
    else if (wr_clr) lvl_q <= lvl_q & ~wbits;
  end

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      OFF_MODE: rdata_o = {{(DW-1){1'b0}}, mode_q};
      OFF_DIR:  rdata_o = {{PADW{1'b0}}, dir_q};
      OFF_LVL:  rdata_o = {{PADW{1'b0}}, pin_sync_i};
      default:  rdata_o = '0;
    endcase
  end

  assign mode_o = mode_q;
  assign dir_o  = dir_q;
  assign lvl_o  = lvl_q;

  AST_MODE_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_mode |=> $stable(mode_q)) else $error("mode changed"); // R2
  AST_DIR_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_dir |=> $stable(dir_q)) else $error("dir changed"); // R3
  AST_SET_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_set |=> ((lvl_q & $past(wbits)) == $past(wbits))) else $error("set"); // R5
  AST_SET_ZERO_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_set |=> ((lvl_q & ~$past(wbits)) == ($past(lvl_q) & ~$past(wbits)))) else $error("set zero"); // R5
  AST_CLR_PULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_clr |=> ((lvl_q & $past(wbits)) == '0)) else $error("clear"); // R6
  AST_CLR_ZERO_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_clr |=> ((lvl_q & ~$past(wbits)) == ($past(lvl_q) & ~$past(wbits)))) else $error("clear zero"); // R6
endmodule

// File: rtl/i2c_rcv_pad.sv
module i2c_rcv_pad (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic mode_i,
  input  logic dir_i,
  input  logic lvl_i,
  input  logic eng_oe_i,
  output logic pad_oe_o
);
  // open drain: a low latch level pulls the line, and only when set as output
  assign pad_oe_o = mode_i ? (dir_i & ~lvl_i) : eng_oe_i;

  AST_INPUT_UNDRIVEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i && !dir_i) |-> !pad_oe_o) else $error("input pad driven"); // R4
endmodule

// File: rtl/i2c_pin_recovery_mux.sv
module i2c_pin_recovery_mux
  import i2c_rcv_pkg::*;
#(
  parameter int unsigned AW = 8,
  parameter int unsigned DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          reg_we_i,
  input  logic [AW-1:0] reg_addr_i,
  input  logic [DW-1:0] reg_wdata_i,
  output logic [DW-1:0] reg_rdata_o,
  input  logic          eng_scl_oe_i,
  input  logic          eng_sda_oe_i,
  input  logic          scl_i,
  input  logic          sda_i,
  output logic          scl_oe_o,
  output logic          sda_oe_o,
  output logic          eng_hold_o
);
  localparam int unsigned NP = NUM_PINS;

  logic [NP-1:0] pin_raw, pin_sync, eng_oe, pad_oe, dir, lvl;
  logic          mode;

  assign pin_raw[PIN_SCL] = scl_i;
  assign pin_raw[PIN_SDA] = sda_i;
  assign eng_oe[PIN_SCL]  = eng_scl_oe_i;
  assign eng_oe[PIN_SDA]  = eng_sda_oe_i;

  i2c_rcv_regs #(
    .AW(AW), .DW(DW), .NP(NP),
    .OFF_MODE(AW'(OFF_MODE)), .OFF_DIR(AW'(OFF_DIR)), .OFF_LVL(AW'(OFF_LVL)),
    .OFF_SET(AW'(OFF_SET)), .OFF_CLR(AW'(OFF_CLR))
  ) u_regs (
    .clk_i, .rst_ni,
    .we_i(reg_we_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i), .rdata_o(reg_rdata_o),
    .pin_sync_i(pin_sync), .mode_o(mode), .dir_o(dir), .lvl_o(lvl)
  );

  for (genvar k = 0; k < NP; k++) begin : g_pin
    i2c_rcv_sync #(.RST_VAL(1'b1)) u_sync (
      .clk_i, .rst_ni, .d_i(pin_raw[k]), .q_o(pin_sync[k])
    );
    i2c_rcv_pad u_pad (
      .clk_i, .rst_ni, .mode_i(mode), .dir_i(dir[k]), .lvl_i(lvl[k]),
      .eng_oe_i(eng_oe[k]), .pad_oe_o(pad_oe[k])
    );
  end

  assign scl_oe_o   = pad_oe[PIN_SCL];
  assign sda_oe_o   = pad_oe[PIN_SDA];
  assign eng_hold_o = mode;

  AST_HOLD_ON_ENTRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && reg_addr_i == AW'(OFF_MODE) && reg_wdata_i[0]) |=> eng_hold_o) else $error("hold"); // R8
  AST_PASS_ENGINE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !eng_hold_o |-> (scl_oe_o == eng_scl_oe_i && sda_oe_o == eng_sda_oe_i)) else $error("pass"); // R2
endmodule

// File: tb/i2c_pin_recovery_mux_tb.sv
`timescale 1ns/1ps
module i2c_pin_recovery_mux_tb_top;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic we = 1'b0;
  logic [7:0] addr = 8'h00;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic e_scl = 1'b0, e_sda = 1'b0, p_scl = 1'b1, p_sda = 1'b1;
  logic scl_oe, sda_oe, hold;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  // model state
  logic       m_mode;
  logic [1:0] m_dir, m_lvl, m_s1, m_s2;

  always #10 clk = ~clk;

  i2c_pin_recovery_mux dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .eng_scl_oe_i(e_scl),
    .eng_sda_oe_i(e_sda), .scl_i(p_scl), .sda_i(p_sda),
    .scl_oe_o(scl_oe), .sda_oe_o(sda_oe), .eng_hold_o(hold)
  );

  function automatic logic exp_oe(input int k, input logic eng);
    return m_mode ? (m_dir[k] & ~m_lvl[k]) : eng;
  endfunction

  function automatic logic [15:0] exp_rd(input logic [7:0] a);
    case (a)
      8'h48: return {15'b0, m_mode};
      8'h4C: return {14'b0, m_dir};
      8'h50: return {14'b0, m_s2};
      default: return 16'h0;
    endcase
  endfunction

  function automatic string rd_tag(input logic [7:0] a);
    case (a)
      8'h48: return "R2";
      8'h4C: return "R3";
      8'h50: return "R7";
      8'h58: return "R5";
      8'h5C: return "R6";
      default: return "R9";
    endcase
  endfunction

  function automatic string oe_tag(input int k);
    if (!m_mode) return "R2";
    if (!m_dir[k]) return "R4";
    return m_lvl[k] ? "R5" : "R6";
  endfunction

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(input logic w, input logic [7:0] a, input logic [15:0] d,
                      input logic es, input logic ed, input logic ps, input logic pd);
    @(negedge clk);
    we = w; addr = a; wdata = d; e_scl = es; e_sda = ed; p_scl = ps; p_sda = pd;
    #2;
    chk(oe_tag(0), {15'b0, scl_oe}, {15'b0, exp_oe(0, es)});
    chk(oe_tag(1), {15'b0, sda_oe}, {15'b0, exp_oe(1, ed)});
    chk("R8", {15'b0, hold}, {15'b0, m_mode});
    if (!w) chk(rd_tag(a), rdata, exp_rd(a));
    @(posedge clk);
    m_s2 = m_s1;
    m_s1 = {pd, ps};
    if (w) begin
      case (a)
        8'h48: m_mode = d[0];
        8'h4C: m_dir = d[1:0];
        8'h58: m_lvl = m_lvl | d[1:0];
        8'h5C: m_lvl = m_lvl & ~d[1:0];
        default: ;
      endcase
    end
  endtask

  initial begin
    #(20 * 5000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [7:0] addrs [7];
    void'($urandom(32'd4242));
    addrs = '{8'h48, 8'h4C, 8'h50, 8'h58, 8'h5C, 8'h54, 8'h00};
    m_mode = 1'b0; m_dir = 2'b00; m_lvl = 2'b11; m_s1 = 2'b11; m_s2 = 2'b11;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;

    // R1 reset state
    step(1'b0, 8'h48, 16'h0, 1'b1, 1'b0, 1'b1, 1'b1);
    chk("R1", {14'b0, sda_oe, scl_oe}, 16'h0001);
    step(1'b0, 8'h4C, 16'h0, 1'b0, 1'b1, 1'b1, 1'b1);
    step(1'b0, 8'h50, 16'h0, 1'b0, 1'b0, 1'b1, 1'b1);

    // enter register mode with SCL output, SDA input
    step(1'b1, 8'h4C, 16'h0001, 1'b0, 1'b0, 1'b1, 1'b1);
    step(1'b1, 8'h48, 16'h0001, 1'b1, 1'b1, 1'b1, 1'b1);
    step(1'b1, 8'h5C, 16'h0003, 1'b1, 1'b1, 1'b1, 1'b1);
    // R4: SDA latch low but SDA is input
    step(1'b0, 8'h48, 16'h0, 1'b1, 1'b1, 1'b1, 1'b1);
    chk("R4", {15'b0, sda_oe}, 16'h0);
    chk("R6", {15'b0, scl_oe}, 16'h1);
    // R5 zero bits: set SCL only, SDA latch stays low
    step(1'b1, 8'h4C, 16'h0003, 1'b0, 1'b0, 1'b1, 1'b1);
    step(1'b1, 8'h58, 16'h0001, 1'b0, 1'b0, 1'b1, 1'b1);
    step(1'b0, 8'h58, 16'h0, 1'b0, 1'b0, 1'b1, 1'b1);
    chk("R5", {14'b0, sda_oe, scl_oe}, 16'h0002);
    // R6 zero bits: clear of zero changes nothing
    step(1'b1, 8'h5C, 16'h0000, 1'b0, 1'b0, 1'b1, 1'b1);
    step(1'b0, 8'h5C, 16'h0, 1'b0, 1'b0, 1'b1, 1'b1);
    chk("R6", {14'b0, sda_oe, scl_oe}, 16'h0002);
    // R9 unmapped write ignored
    step(1'b1, 8'h54, 16'hFFFF, 1'b0, 1'b0, 1'b1, 1'b1);
    step(1'b0, 8'h4C, 16'h0, 1'b0, 1'b0, 1'b1, 1'b1);
    chk("R9", rdata, 16'h0003);

    // R7 latency: pull SCL low while reading
    step(1'b0, 8'h50, 16'h0, 1'b0, 1'b0, 1'b0, 1'b1);
    chk("R7", rdata, 16'h0003);
    step(1'b0, 8'h50, 16'h0, 1'b0, 1'b0, 1'b0, 1'b1);
    chk("R7", rdata, 16'h0003);
    step(1'b0, 8'h50, 16'h0, 1'b0, 1'b0, 1'b0, 1'b1);
    chk("R7", rdata, 16'h0002);

    // R2 leave register mode while engine toggles
    step(1'b1, 8'h48, 16'h0000, 1'b0, 1'b1, 1'b1, 1'b1);
    step(1'b0, 8'h48, 16'h0, 1'b1, 1'b0, 1'b1, 1'b1);
    chk("R2", {14'b0, sda_oe, scl_oe}, 16'h0001);

    // random mix
    for (int i = 0; i < 1500; i++) begin
      logic [7:0] a;
      logic [15:0] d;
      a = addrs[$urandom_range(0, 6)];
      d = 16'($urandom);
      step(($urandom_range(0, 2) == 0), a, d, 1'($urandom), 1'($urandom),
           1'($urandom), 1'($urandom));
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule